// File: doc/BRIEF.md
# Chained Crosspoint Serial Programming Sequencer

This block sits on the host side of a board and loads a whole chain of 8×8 crosspoint switch devices in one go through their shared serial programming interface. Every device in the chain gets a table of eight outputs. Each output entry is a 3-bit input select plus an enable bit. When the block sees a request, it takes a copy of the full table. It then drives a divided serial clock, the data line, an active-low chip enable, a mode select (held low for serial mode) and an active-low update strobe. When the update pulse ends, it raises a one-cycle done flag.

The devices are wired data-out to data-in, so the first bit shifted ends up in the device farthest down the chain. The sequencer therefore sends the table of the last device first and the table of device 0 last. Within each device it walks the outputs from index 7 down to index 0. Update stays high for all 32×N shifts, so the devices never pass through intermediate states. After the last bit, one low update pulse applies the new configuration to every device at the same moment.

The serial clock is derived from the system clock. Each of its half periods lasts `half_div` system cycles. The devices sample data on the falling edge, and the sequencer changes data only on the rising edge.

Top module: `xpt_chain_prog`

## Requirements
- R1: An accepted request produces exactly 32×NUM_DEV falling edges on `xp_clk`. One data bit is transferred per falling edge.
- R2: Device d output o takes its select from `cfg_src[(d*8+o)*3 +: 3]` and its enable from `cfg_en[d*8+o]`. The bits of device NUM_DEV-1 are sent first and the bits of device 0 last.
- R3: Within one device, the 4-bit groups are sent for output 7 first, then descending, with output 0 last.
- R4: Each output's group is sent in the order select bit 0, select bit 1, select bit 2, enable bit.
- R5: `xp_ce_n` and `xp_mode_sel` are low from the cycle after an accepted request until the update pulse ends. They are high when idle.
- R6: `xp_update` stays high during shifting. After the last falling edge it goes low exactly once, for 2×H system cycles, with `xp_clk` high, `xp_data` low and `xp_ce_n` low.
- R7: `xp_data` changes only together with a rising edge of `xp_clk`. It never changes while the clock is low, nor on a falling edge.
- R8: Every half period of `xp_clk` lasts H system cycles, where H = `half_div`. A value of 0 acts as 1, so falling edges are 2×H cycles apart.
- R9: `done` is high for exactly one cycle: the cycle in which `xp_update` returns high and `xp_ce_n` returns high.
- R10: A `start` pulse while a sequence is running is ignored. No extra bits are shifted and no second sequence follows.
- R11: The table is captured on the cycle the request is accepted. Changes to `cfg_src` or `cfg_en` after that have no effect on the bits sent.
- R12: Reset (asynchronous, active low) forces `xp_clk`=1, `xp_ce_n`=1, `xp_mode_sel`=1, `xp_update`=1, `xp_data`=0 and `done`=0, including in the middle of a sequence. The clock also rests high after a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse, accepted only when idle |
| half_div | input | DIV_W | System cycles per half period of the serial clock (0 acts as 1) |
| cfg_src | input | NUM_DEV*24 | 3-bit input select per output per device |
| cfg_en | input | NUM_DEV*8 | Enable bit per output per device |
| xp_clk | output | 1 | Serial clock to the chain; idles high |
| xp_data | output | 1 | Serial data to the first device |
| xp_ce_n | output | 1 | Active-low chip enable shared by the chain |
| xp_mode_sel | output | 1 | Low selects serial programming mode |
| xp_update | output | 1 | Active-low strobe that applies the shifted configuration |
| done | output | 1 | One-cycle completion flag |

## Verification
The table is driven with several patterns, and each pattern exposes a different class of fault:
- All zeros and all ones expose stuck data and a wrong bit count.
- A walking select with alternating enables catches swapped select bits and an enable placed at the wrong position in a group.
- Hashed patterns, which differ between devices, catch reversed device order and reversed output order.

Divider values of 0, 1, 2 and 3 separate a correct half period from off-by-one counting. One run fires a second request and inverts the table mid-sequence, which exposes both a restart and a missing snapshot. A reset in the middle of a sequence shows that the pins return to idle at once.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int OUTS_PER_DEV = 8;
  localparam int SRC_W        = 3;
  localparam int GRP_BITS     = SRC_W + 1;
  localparam int BITS_PER_DEV = OUTS_PER_DEV * GRP_BITS;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SHIFT_HI = 3'd1,
    ST_SHIFT_LO = 3'd2,
    ST_UPD_A    = 3'd3,
    ST_UPD_B    = 3'd4
  } seq_state_t;
endpackage

// File: rtl/xpt_half_tick.sv
module xpt_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] lim_m1;

  // A zero divider behaves as one system cycle per half period.
  always_comb begin
    lim_m1 = (half_div == '0) ? '0 : half_div - DIV_W'(1);
    tick   = run && (cnt_q >= lim_m1);
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R8: each half period starts counting from zero
  assert_fresh_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(tick)) |-> (cnt_q == '0));
endmodule

// File: rtl/xpt_frame_pick.sv
module xpt_frame_pick
  import xpt_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int IDX_W   = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic [NUM_DEV*OUTS_PER_DEV*SRC_W-1:0] cfg_src,
  input  logic [NUM_DEV*OUTS_PER_DEV-1:0]       cfg_en,
  input  logic [IDX_W-1:0]                  pick_idx,
  output logic                              pick_bit
);
  localparam int SRC_BITS = NUM_DEV * OUTS_PER_DEV * SRC_W;
  localparam int EN_BITS  = NUM_DEV * OUTS_PER_DEV;
  localparam int SRC_IW   = $clog2(SRC_BITS);
  localparam int EN_IW    = $clog2(EN_BITS);

  logic [SRC_BITS-1:0] snap_src;
  logic [EN_BITS-1:0]  snap_en;
  logic [SRC_BITS-1:0] src_v;
  logic [EN_BITS-1:0]  en_v;

  // Per-device snapshot slices, loaded on an accepted request.
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap_src[d*OUTS_PER_DEV*SRC_W +: OUTS_PER_DEV*SRC_W] <= '0;
        snap_en[d*OUTS_PER_DEV +: OUTS_PER_DEV]               <= '0;
      end else if (load) begin
        snap_src[d*OUTS_PER_DEV*SRC_W +: OUTS_PER_DEV*SRC_W] <=
          cfg_src[d*OUTS_PER_DEV*SRC_W +: OUTS_PER_DEV*SRC_W];
        snap_en[d*OUTS_PER_DEV +: OUTS_PER_DEV] <=
          cfg_en[d*OUTS_PER_DEV +: OUTS_PER_DEV];
      end
    end
  end

  int k_i, dev_i, slot_i, out_i, pos_i, flat_i;

  // The first bit leaves before the snapshot is written, so it is taken from the live table.
  always_comb begin
    src_v  = load ? cfg_src : snap_src;
    en_v   = load ? cfg_en  : snap_en;
    k_i    = int'(pick_idx);
    dev_i  = NUM_DEV - 1 - (k_i / BITS_PER_DEV);
    slot_i = k_i % BITS_PER_DEV;
    out_i  = OUTS_PER_DEV - 1 - (slot_i / GRP_BITS);
    pos_i  = slot_i % GRP_BITS;
    flat_i = dev_i * OUTS_PER_DEV + out_i;
    if (pos_i == SRC_W) pick_bit = en_v[EN_IW'(flat_i)];
    else                pick_bit = src_v[SRC_IW'(flat_i * SRC_W + pos_i)];
  end

  // R11: the captured table is held between requests
  assert_snap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(snap_src) && $stable(snap_en)));
endmodule

// File: rtl/xpt_seq_ctrl.sv
module xpt_seq_ctrl
  import xpt_pkg::*;
#(
  parameter int TOT_BITS = 64,
  parameter int IDX_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic             pick_bit,
  output logic             run,
  output logic             load,
  output logic [IDX_W-1:0] pick_idx,
  output logic             xp_clk,
  output logic             xp_data,
  output logic             xp_ce_n,
  output logic             xp_mode_sel,
  output logic             xp_update,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOT_BITS - 1);

  seq_state_t       state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             shift_n;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_n = ST_SHIFT_HI;
        idx_n   = '0;
        load    = 1'b1;
      end
      ST_SHIFT_HI: if (tick) state_n = ST_SHIFT_LO;
      ST_SHIFT_LO: if (tick) begin
        if (idx_q == LAST_IDX) state_n = ST_UPD_A;
        else begin
          idx_n   = idx_q + IDX_W'(1);
          state_n = ST_SHIFT_HI;
        end
      end
      ST_UPD_A: if (tick) state_n = ST_UPD_B;
      ST_UPD_B: if (tick) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
    shift_n  = (state_n == ST_SHIFT_HI) || (state_n == ST_SHIFT_LO);
    pick_idx = idx_n;
    run      = (state_q != ST_IDLE);
  end

  // Pins are registered from the next state, so they are free of glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      xp_clk      <= 1'b1;
      xp_data     <= 1'b0;
      xp_ce_n     <= 1'b1;
      xp_mode_sel <= 1'b1;
      xp_update   <= 1'b1;
      done        <= 1'b0;
    end else begin
      state_q     <= state_n;
      idx_q       <= idx_n;
      xp_clk      <= (state_n != ST_SHIFT_LO);
      xp_data     <= shift_n ? pick_bit : 1'b0;
      xp_ce_n     <= (state_n == ST_IDLE);
      xp_mode_sel <= (state_n == ST_IDLE);
      xp_update   <= !((state_n == ST_UPD_A) || (state_n == ST_UPD_B));
      done        <= (state_q == ST_UPD_B) && tick;
    end
  end

  // R1: bit index stays inside the frame
  assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);
  // R5: chain selected in serial mode whenever a sequence runs
  assert_sel_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (!xp_ce_n && !xp_mode_sel));
  // R6: update pulse only with clock high, data low, chip selected
  assert_upd_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !xp_update |-> (xp_clk && !xp_data && !xp_ce_n));
  // R7: data held while the serial clock is low
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!xp_clk && $past(!xp_clk)) |-> $stable(xp_data));
  // R9: done lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: done coincides with the end of the update pulse
  assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xp_update) |-> done);
  // R10: a request during a running sequence does not restart it
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT_LO && start && !tick) |=> (state_q == ST_SHIFT_LO));
endmodule

// File: rtl/xpt_chain_prog.sv
module xpt_chain_prog
  import xpt_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int DIV_W   = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [DIV_W-1:0]                      half_div,
  input  logic [NUM_DEV*OUTS_PER_DEV*SRC_W-1:0] cfg_src,
  input  logic [NUM_DEV*OUTS_PER_DEV-1:0]       cfg_en,
  output logic                                  xp_clk,
  output logic                                  xp_data,
  output logic                                  xp_ce_n,
  output logic                                  xp_mode_sel,
  output logic                                  xp_update,
  output logic                                  done
);
  localparam int TOT_BITS = NUM_DEV * BITS_PER_DEV;
  localparam int IDX_W    = $clog2(TOT_BITS);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             run, tick, load, pick_bit;
  logic [IDX_W-1:0] pick_idx;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  xpt_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .run(run), .half_div(half_div), .tick(tick)
  );

  xpt_frame_pick #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_int_n), .load(load), .cfg_src(cfg_src),
    .cfg_en(cfg_en), .pick_idx(pick_idx), .pick_bit(pick_bit)
  );

  xpt_seq_ctrl #(.TOT_BITS(TOT_BITS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .tick(tick),
    .pick_bit(pick_bit), .run(run), .load(load), .pick_idx(pick_idx),
    .xp_clk(xp_clk), .xp_data(xp_data), .xp_ce_n(xp_ce_n),
    .xp_mode_sel(xp_mode_sel), .xp_update(xp_update), .done(done)
  );
endmodule

// File: tb/xpt_chain_prog_tb.sv
module xpt_chain_prog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ND  = 3;
  localparam int TOT = ND * 32;
  localparam int NV  = 6;
  // {half_div[7:0], pattern[3:0], disturb}
  localparam logic [12:0] VEC [NV] = '{
    {8'd1, 4'd0, 1'b0}, {8'd1, 4'd1, 1'b0}, {8'd2, 4'd2, 1'b0},
    {8'd3, 4'd3, 1'b1}, {8'd0, 4'd4, 1'b0}, {8'd2, 4'd3, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] half_div = 8'd1;
  logic [ND*24-1:0] cfg_src = '0;
  logic [ND*8-1:0]  cfg_en = '0;
  logic xp_clk, xp_data, xp_ce_n, xp_mode_sel, xp_update, done;

  int n_chk = 0, n_bad = 0;
  bit mon_on = 0;
  int cyc, nfall, last_fall, heff, upd_len, upd_pulses, done_cnt;
  int bad_ctrl, bad_data, bad_period, bad_upd, bad_done;
  logic pclk, pdata, pupd, pdone;
  logic [255:0] cap, expf;

  xpt_chain_prog #(.NUM_DEV(ND), .DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
    .cfg_src(cfg_src), .cfg_en(cfg_en), .xp_clk(xp_clk), .xp_data(xp_data),
    .xp_ce_n(xp_ce_n), .xp_mode_sel(xp_mode_sel), .xp_update(xp_update),
    .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] frame_of(input logic [ND*24-1:0] s,
                                            input logic [ND*8-1:0] e);
    logic [255:0] r = '0;
    int k = 0;
    for (int d = ND - 1; d >= 0; d--)
      for (int o = 7; o >= 0; o--) begin
        int f = d * 8 + o;
        r[k] = s[f*3]; r[k+1] = s[f*3+1]; r[k+2] = s[f*3+2]; r[k+3] = e[f];
        k += 4;
      end
    return r;
  endfunction

  task automatic set_cfg(input int mode);
    for (int i = 0; i < ND * 8; i++) begin
      logic [2:0] s; logic en;
      case (mode)
        0: begin s = 3'd0; en = 1'b0; end
        1: begin s = 3'd7; en = 1'b1; end
        2: begin s = 3'(i % 8); en = 1'(i % 2); end
        3: begin s = 3'((i * 5 + 3) % 8); en = 1'((i / 3) % 2); end
        default: begin s = 3'(7 - (i % 8)); en = (i != 5); end
      endcase
      cfg_src[i*3 +: 3] = s;
      cfg_en[i] = en;
    end
  endtask

  task automatic mon_reset(input int h);
    cyc = 0; nfall = 0; last_fall = -1; upd_len = 0; upd_pulses = 0;
    done_cnt = 0; bad_ctrl = 0; bad_data = 0; bad_period = 0; bad_upd = 0;
    bad_done = 0; cap = '0; heff = (h == 0) ? 1 : h;
    pclk = 1'b1; pdata = 1'b0; pupd = 1'b1; pdone = 1'b0;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (pclk && !xp_clk) begin
        if (xp_ce_n || xp_mode_sel || !xp_update) bad_ctrl++;
        if (nfall < 256) cap[nfall] = xp_data;
        nfall++;
        if (last_fall >= 0 && (cyc - last_fall) != 2 * heff) bad_period++;
        last_fall = cyc;
        if (xp_data != pdata) bad_data++;
      end else if (!xp_clk && !pclk && xp_data != pdata) bad_data++;
      if (!xp_update) begin
        upd_len++;
        if (xp_ce_n || xp_mode_sel || !xp_clk || xp_data) bad_upd++;
        if (nfall != TOT) bad_upd++;
      end
      if (pupd && !xp_update) upd_pulses++;
      if (done) begin
        done_cnt++;
        if (pupd || !xp_update || !xp_ce_n || pdone) bad_done++;
      end
      pclk = xp_clk; pdata = xp_data; pupd = xp_update; pdone = done;
    end
  end

  task automatic run_vec(input int h, input int mode, input bit disturb);
    logic [ND*24-1:0] s0; logic [ND*8-1:0] e0;
    int waited = 0;
    @(negedge clk);
    set_cfg(mode); half_div = 8'(h);
    s0 = cfg_src; e0 = cfg_en; expf = frame_of(s0, e0);
    mon_reset(h); mon_on = 1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (disturb) begin
      repeat (40) @(negedge clk);
      start = 1'b1; cfg_src = ~cfg_src; cfg_en = ~cfg_en;
      @(negedge clk); start = 1'b0;
    end
    while (done_cnt == 0 && waited < 5000) begin @(negedge clk); waited++; end
    repeat (30) @(negedge clk);
    chk(done_cnt > 0, "R9 done seen", 256'(done_cnt), 256'd1);
    chk(nfall == TOT, "R1 bit count", 256'(nfall), 256'(TOT));
    chk(cap == expf, "R2 R3 R4 frame order", cap, expf);
    chk(bad_ctrl == 0 && xp_ce_n && xp_mode_sel, "R5 select lines",
        256'(bad_ctrl), 256'd0);
    chk(upd_pulses == 1 && upd_len == 2 * heff && bad_upd == 0,
        "R6 update pulse", 256'(upd_len), 256'(2 * heff));
    chk(bad_data == 0, "R7 data edge", 256'(bad_data), 256'd0);
    chk(bad_period == 0 && last_fall >= 0, "R8 clock period",
        256'(bad_period), 256'd0);
    chk(done_cnt == 1 && bad_done == 0, "R9 done pulse", 256'(done_cnt), 256'd1);
    chk(xp_clk == 1'b1, "R12 clock rests high", 256'(xp_clk), 256'd1);
    if (disturb) begin
      chk(upd_pulses == 1 && nfall == TOT, "R10 busy request ignored",
          256'(upd_pulses), 256'd1);
      chk(cap == frame_of(s0, e0) && cap != frame_of(cfg_src, cfg_en),
          "R11 table captured at request", cap, frame_of(s0, e0));
    end
    mon_on = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(xp_clk && xp_ce_n && xp_mode_sel && xp_update && !xp_data && !done,
        "R12 reset state", 256'({xp_clk, xp_ce_n, xp_mode_sel, xp_update, xp_data, done}),
        256'(6'b111100));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_vec(int'(VEC[v][12:5]), int'(VEC[v][4:1]), VEC[v][0]);

    // Reset in the middle of a sequence returns the pins to idle at once.
    set_cfg(1); half_div = 8'd2;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (51) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(xp_clk && xp_ce_n && xp_mode_sel && xp_update && !xp_data && !done,
        "R12 mid-sequence reset", 256'({xp_clk, xp_ce_n, xp_mode_sel, xp_update, xp_data, done}),
        256'(6'b111100));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(xp_ce_n && xp_update, "R12 idle after reset", 256'({xp_ce_n, xp_update}), 256'd3);

    // A sequence after the reset still completes correctly.
    run_vec(1, 3, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule